// File: doc/BRIEF.md
# Cascaded ISA Interrupt Router

This block takes sixteen ISA interrupt request lines and turns them into two CPU interrupt lines. Requests arrive one event per clock as a line number plus a set-or-clear flag. Lines 0 to 7 land in a primary request register and lines 8 to 15 land in a secondary one. Each bank has its own mask register. Any unmasked secondary request shows up in position 2 of the primary bank. A selector mask then divides the unmasked primary requests between a "local" CPU line and an "ISA" CPU line.

A small counter keeps track of timer interrupts that are still awaiting acknowledgement. The timer source raises an increment input. Clearing request line 0 while its bit is set acknowledges one pending tick. The two masks and the selector are loaded through a narrow write port.

Top module: `isa_irq_router`

## Requirements
- R1: After reset, both CPU outputs are 0 and the timer count is 0. Both mask registers reset to 0x00 and the selector resets to 0x18, so lines 3 and 4 go to the local output.
- R2: An event with `evt_valid=1` and `evt_set=1` sets a request bit, and one with `evt_set=0` clears it. Lines 0–7 address primary bit `line`. Lines 8–15 address secondary bit `line-8`.
- R3: A request bit counts as pending only while its mask bit is 0. A mask bit of 1 hides the request from both outputs, but the stored request is kept.
- R4: Primary position 2 follows the secondary bank: it is 1 exactly when some secondary request is set with its mask bit clear. Line 2 on its own never affects the outputs.
- R5: `irq_local` is 1 when a pending primary bit lies inside the selector. `irq_isa` is 1 when a pending primary bit lies outside it. Both are registered and reflect the state one clock edge after the edge that changed it.
- R6: Line numbers 16 to 31 change no request bit. They only cause the outputs to be re-evaluated, as they are every cycle anyway.
- R7: A clear event on line 0 while primary bit 0 is set decrements a non-zero timer count by one, on the same edge. Any other clear of line 0 leaves the count alone.
- R8: `tmr_inc` adds one to the count and saturates at 255. If an increment and a decrement happen on the same edge, the count is unchanged.
- R9: A write with `cfg_we=1` loads address 0 into the primary mask, 1 into the secondary mask and 2 into the selector. Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | A request event is present this cycle |
| evt_line | input | 5 | Request line number (0–15 real, 16–31 re-evaluate only) |
| evt_set | input | 1 | 1 sets the request bit, 0 clears it |
| tmr_inc | input | 1 | Timer source raised one more tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 primary mask, 1 secondary mask, 2 selector, 3 unused |
| cfg_wdata | input | 8 | Configuration write data |
| irq_local | output | 1 | CPU interrupt for pending lines inside the selector |
| irq_isa | output | 1 | CPU interrupt for pending lines outside the selector |
| tmr_pending | output | 8 | Count of unacknowledged timer ticks |

## Verification
The properties assume at most one request event and one configuration write per clock, with inputs stable around the rising edge and no X on them once the internal reset has been released. The stimulus drives every input on the falling edge. It leaves the block in reset until the two-stage release has finished, and it applies events only afterwards. Random phases take line numbers from the whole 5-bit range, including the re-evaluate codes. They also pick random mask and selector writes, including the unused address, so every combination stays inside the one-event-per-cycle contract.

// File: rtl/isa_irq_pkg.sv
`timescale 1ns/1ps
package isa_irq_pkg;
  localparam int BANK_W    = 8;
  localparam int LINE_W    = 5;
  localparam int CNT_W     = 8;
  localparam int CASC_BIT  = 2;
  localparam int SEL_RESET = 8'h18;

  typedef enum logic [1:0] {
    CFG_PMASK = 2'd0,
    CFG_SMASK = 2'd1,
    CFG_SEL   = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_req_bank.sv
`timescale 1ns/1ps
module irq_req_bank #(
  parameter int W        = 8,
  parameter int LINE_W   = 5,
  parameter int BANK_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [LINE_W-1:0] ev_line,
  input  logic              ev_set,
  output logic [W-1:0]      req,
  output logic [W-1:0]      clr_hit
);
  localparam int IDX_W = $clog2(W);
  localparam int SEL_W = LINE_W - IDX_W;

  logic           bank_hit;
  logic [W-1:0]   req_d;
  logic [W-1:0]   req_q;
  logic           req_en;

  assign bank_hit = ev_valid && (ev_line[LINE_W-1:IDX_W] == SEL_W'(BANK_IDX));
  assign req_en   = bank_hit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_sel;
    assign bit_sel    = (ev_line[IDX_W-1:0] == IDX_W'(i));
    assign req_d[i]   = bit_sel ? ev_set : req_q[i];
    assign clr_hit[i] = bank_hit && bit_sel && !ev_set && req_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import isa_irq_pkg::*;
#(
  parameter int W         = BANK_W,
  parameter int SEL_INIT  = SEL_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pmask,
  output logic [W-1:0] smask,
  output logic [W-1:0] sel
);
  logic [W-1:0] pmask_q, smask_q, sel_q;
  logic         pmask_en, smask_en, sel_en;
  cfg_addr_e    dec;

  assign dec = cfg_addr_e'(addr);

  always_comb begin
    pmask_en = 1'b0;
    smask_en = 1'b0;
    sel_en   = 1'b0;
    if (we) begin
      unique case (dec)
        CFG_PMASK: pmask_en = 1'b1;
        CFG_SMASK: smask_en = 1'b1;
        CFG_SEL:   sel_en   = 1'b1;
        CFG_NONE:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pmask_q <= '0;
    else if (pmask_en) pmask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        smask_q <= '0;
    else if (smask_en) smask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= W'(SEL_INIT);
    else if (sel_en) sel_q <= wdata;
  end

  assign pmask = pmask_q;
  assign smask = smask_q;
  assign sel   = sel_q;
endmodule

// File: rtl/irq_route.sv
`timescale 1ns/1ps
module irq_route #(
  parameter int W        = 8,
  parameter int CASC_BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] prim_req,
  input  logic [W-1:0] sec_req,
  input  logic [W-1:0] pmask,
  input  logic [W-1:0] smask,
  input  logic [W-1:0] sel,
  output logic [W-1:0] prim_pend,
  output logic         irq_local,
  output logic         irq_isa
);
  localparam logic [W-1:0] CASC_ONEHOT = W'(1) << CASC_BIT;

  logic         casc;
  logic [W-1:0] prim_eff;
  logic         local_d, isa_d;
  logic         local_q, isa_q;

  always_comb begin
    casc      = |(sec_req & ~smask);
    prim_eff  = (prim_req & ~CASC_ONEHOT) | (casc ? CASC_ONEHOT : '0);
    prim_pend = prim_eff & ~pmask;
    local_d   = |(prim_pend & sel);
    isa_d     = |(prim_pend & ~sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_q <= 1'b0;
      isa_q   <= 1'b0;
    end else begin
      local_q <= local_d;
      isa_q   <= isa_d;
    end
  end

  assign irq_local = local_q;
  assign irq_isa   = isa_q;
endmodule

// File: rtl/irq_tmr_ack.sv
`timescale 1ns/1ps
module irq_tmr_ack #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ack,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok, inc_ok, cnt_en;

  always_comb begin
    dec_ok = ack && (cnt_q != '0);
    inc_ok = inc && ((cnt_q != CNT_MAX) || dec_ok);
    cnt_en = dec_ok ^ inc_ok;
    cnt_d  = cnt_q;
    if (inc_ok && !dec_ok)      cnt_d = cnt_q + CNT_W'(1);
    else if (dec_ok && !inc_ok) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/isa_irq_router.sv
`timescale 1ns/1ps
module isa_irq_router
  import isa_irq_pkg::*;
#(
  parameter int W        = BANK_W,
  parameter int LW       = LINE_W,
  parameter int CW       = CNT_W,
  parameter int CASC     = CASC_BIT,
  parameter int SEL_INIT = SEL_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [LW-1:0] evt_line,
  input  logic          evt_set,
  input  logic          tmr_inc,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  output logic          irq_local,
  output logic          irq_isa,
  output logic [CW-1:0] tmr_pending
);
  localparam int NUM_BANKS = 2;

  logic                rst_sync_n;
  logic [W-1:0]        bank_req [NUM_BANKS];
  logic [W-1:0]        bank_clr [NUM_BANKS];
  logic [W-1:0]        pmask, smask, sel;
  logic [W-1:0]        prim_pend;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_req_bank #(.W(W), .LINE_W(LW), .BANK_IDX(b)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ev_valid (evt_valid),
      .ev_line  (evt_line),
      .ev_set   (evt_set),
      .req      (bank_req[b]),
      .clr_hit  (bank_clr[b])
    );
  end

  irq_cfg_regs #(.W(W), .SEL_INIT(SEL_INIT)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .pmask (pmask),
    .smask (smask),
    .sel   (sel)
  );

  irq_route #(.W(W), .CASC_BIT(CASC)) u_route (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .prim_req  (bank_req[0]),
    .sec_req   (bank_req[1]),
    .pmask     (pmask),
    .smask     (smask),
    .sel       (sel),
    .prim_pend (prim_pend),
    .irq_local (irq_local),
    .irq_isa   (irq_isa)
  );

  irq_tmr_ack #(.CNT_W(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (tmr_inc),
    .ack   (bank_clr[0][0]),
    .cnt   (tmr_pending)
  );
endmodule

// File: rtl/isa_irq_router_chk.sv
`timescale 1ns/1ps
module isa_irq_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [4:0] evt_line,
  input logic       evt_set,
  input logic       tmr_inc,
  input logic       cfg_we,
  input logic [1:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] pmask,
  input logic [7:0] sel,
  input logic       irq_local,
  input logic       irq_isa,
  input logic [7:0] tmr_pending
);
  logic line0_clear;
  assign line0_clear = evt_valid && !evt_set && (evt_line == 5'd0);

  // R3: a fully masked primary bank silences both outputs
  a_r3_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pmask == 8'hFF) |=> (!irq_local && !irq_isa));

  // R5: an empty selector never raises the local output
  a_r5_local_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 8'h00) |=> !irq_local);

  // R5: a full selector never raises the ISA output
  a_r5_isa_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 8'hFF) |=> !irq_isa);

  // R7: without a clear of line 0 the count never falls
  a_r7_no_dec: assert property (@(posedge clk) disable iff (!rst_n)
    !line0_clear |=> (tmr_pending >= $past(tmr_pending)));

  // R8: saturation holds under increment
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_pending == 8'hFF && tmr_inc) |=> (tmr_pending == 8'hFF));

  // R8: the count moves by at most one per edge
  a_r8_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tmr_pending == $past(tmr_pending)) ||
              (tmr_pending == $past(tmr_pending) + 8'd1) ||
              (tmr_pending == $past(tmr_pending) - 8'd1)));

  // R9: a selector write lands on the next edge
  a_r9_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2) |=> (sel == $past(cfg_wdata)));
endmodule

bind isa_irq_router isa_irq_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .evt_valid   (evt_valid),
  .evt_line    (evt_line),
  .evt_set     (evt_set),
  .tmr_inc     (tmr_inc),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .pmask       (pmask),
  .sel         (sel),
  .irq_local   (irq_local),
  .irq_isa     (irq_isa),
  .tmr_pending (tmr_pending)
);

// File: tb/isa_irq_router_tb.sv
`timescale 1ns/1ps
module isa_irq_router_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_valid, evt_set, tmr_inc, cfg_we;
  logic [4:0] evt_line;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       irq_local, irq_isa;
  logic [7:0] tmr_pending;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_req [16];
  int m_pmask, m_smask, m_sel, m_cnt;
  int m_local, m_isa;

  always #4 clk = ~clk;

  isa_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_line(evt_line),
    .evt_set(evt_set), .tmr_inc(tmr_inc), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_local(irq_local), .irq_isa(irq_isa),
    .tmr_pending(tmr_pending)
  );

  function automatic int prim_pending();
    int secany = 0;
    int p = 0;
    for (int i = 0; i < 8; i++)
      if (m_req[8+i] != 0 && ((m_smask >> i) & 1) == 0) secany = 1;
    for (int i = 0; i < 8; i++) begin
      int r = (i == 2) ? secany : m_req[i];
      if (r != 0 && ((m_pmask >> i) & 1) == 0) p |= (1 << i);
    end
    return p;
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (irq_local !== m_local[0] || irq_isa !== m_isa[0] || tmr_pending !== m_cnt[7:0]) begin
      n_bad++;
      $display("FAIL %s: local/isa/cnt actual %0b/%0b/%0d expected %0d/%0d/%0d",
               tag, irq_local, irq_isa, tmr_pending, m_local, m_isa, m_cnt);
    end
  endtask

  task automatic step(input bit v, input int line, input bit s, input bit inc,
                      input bit we, input int addr, input int data, input string tag);
    int p;
    int dec;
    evt_valid = v; evt_line = line[4:0]; evt_set = s; tmr_inc = inc;
    cfg_we = we; cfg_addr = addr[1:0]; cfg_wdata = data[7:0];
    @(posedge clk);
    p = prim_pending();
    m_local = ((p & m_sel) != 0) ? 1 : 0;
    m_isa   = ((p & ~m_sel & 8'hFF) != 0) ? 1 : 0;
    dec = (v && !s && line == 0 && m_req[0] != 0 && m_cnt > 0) ? 1 : 0;
    m_cnt = m_cnt - dec + (inc ? 1 : 0);
    if (m_cnt > 255) m_cnt = 255;
    if (v && line < 16) m_req[line] = s ? 1 : 0;
    if (we) begin
      if (addr == 0) m_pmask = data & 8'hFF;
      else if (addr == 1) m_smask = data & 8'hFF;
      else if (addr == 2) m_sel = data & 8'hFF;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic ev(input int line, input bit s, input string tag);
    step(1, line, s, 0, 0, 0, 0, tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input int addr, input int data, input string tag);
    step(0, 0, 0, 0, 1, addr, data, tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    evt_valid = 0; evt_line = 0; evt_set = 0; tmr_inc = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    for (int i = 0; i < 16; i++) m_req[i] = 0;
    m_pmask = 0; m_smask = 0; m_sel = 8'h18; m_cnt = 0; m_local = 0; m_isa = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release");

    ev(5, 1, "R2 primary line 5 to isa");
    ev(3, 1, "R5 line 3 to local");
    ev(5, 0, "R2 clear line 5");
    ev(3, 0, "R2 clear line 3");
    cfg(0, 8'h08, "R9 primary mask write");
    ev(3, 1, "R3 masked line 3");
    cfg(0, 8'h00, "R3 unmask keeps request");
    ev(3, 0, "R2 clear line 3 again");
    ev(2, 1, "R4 line 2 alone ignored");
    ev(10, 1, "R4 secondary cascade");
    cfg(1, 8'h04, "R3 secondary mask hides cascade");
    cfg(1, 8'h00, "R4 cascade restored");
    cfg(2, 8'h04, "R9 selector moves cascade to local");
    cfg(3, 8'hFF, "R9 address 3 ignored");
    ev(16, 1, "R6 line 16 no change");
    ev(23, 0, "R6 line 23 no change");
    ev(10, 0, "R2 clear secondary line");
    ev(2, 0, "R4 clear line 2");
    cfg(2, 8'h18, "R1 selector default restored");

    // timer acknowledge
    ev(0, 0, "R7 clear line 0 with zero count");
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 0, 0, "R8 increment");
    ev(0, 1, "R2 set line 0");
    ev(0, 0, "R7 ack decrements");
    ev(0, 0, "R7 second clear no change");
    ev(0, 1, "R2 set line 0 again");
    step(1, 0, 0, 1, 0, 0, 0, "R8 inc with dec unchanged");
    for (int k = 0; k < 260; k++) step(0, 0, 0, 1, 0, 0, 0, "R8 saturate");
    ev(0, 1, "R2 set line 0 at max");
    step(1, 0, 0, 1, 0, 0, 0, "R8 inc with dec at max");
    ev(0, 1, "R2 set line 0");
    ev(0, 0, "R7 ack from max");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      bit v, s, inc, we;
      int line, addr, data;
      v    = ($urandom % 3) != 0;
      line = $urandom % 18;
      if (($urandom % 8) == 0) line = 16 + ($urandom % 16);
      s    = $urandom % 2;
      inc  = ($urandom % 6) == 0;
      we   = ($urandom % 10) == 0;
      addr = $urandom % 4;
      data = ($urandom % 4 == 0) ? 0 : ($urandom % 256);
      step(v, line, s, inc, we, addr, data, "R5 random routing");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule